// File: doc/BRIEF.md
# Command Packet Header Parser

This block sits on a stream of 32-bit command words. It treats the first word it sees as a packet header and works out the header format from the top nibble. It pulls out the payload count and either a register index or an opcode. For the two formats that carry parity bits, it checks those bits. It then lets the header's payload words pass to its output stream and tags each word with its role. A word is tagged either as a write to a register, with the index rising by one per word, or as an argument to an opcode. When the last payload word has been taken, the next input word is parsed as a new header.

Both word streams use valid/ready. While the parser waits for a header, `in_ready` is high. A header is taken in one cycle whatever `pl_ready` is doing. During a payload the input is passed through with no storage: `pl_valid` follows `in_valid` and `in_ready` follows `pl_ready`. A stall on the output therefore holds the upstream source in the same cycle. Each header produces exactly one of three one-cycle pulses on the cycle after it is taken: decoded fields, unknown type, or parity mismatch.

Top module: `cmd_hdr_parser`

## Requirements
- R1: The header type comes from bits [31:28]. 0x0 selects type 0, 0x8 type 2, 0xC type 3, 0x4 type 4 and 0x7 type 7. Any other nibble gives an `err_bad_type` pulse and the word is dropped. The word that follows is then parsed as a header.
- R2: A type-0 header carries a register index in bits [14:0] and the payload count minus one in bits [27:16]. Its payload words come out with `pl_is_reg`=1, and `pl_reg` starts at that index.
- R3: A type-3 header carries an opcode in bits [15:8] and the payload count minus one in bits [27:16]. Its payload words come out with `pl_is_reg`=0 and with `pl_opc` equal to that opcode.
- R4: A type-4 header carries the count in bits [6:0], the count's parity in bit 7, an 18-bit register index in bits [25:8], and the index's parity in bit 27. Its payload is tagged as register writes.
- R5: A type-7 header carries the count in bits [13:0], the count's parity in bit 15, a 7-bit opcode in bits [22:16], and the opcode's parity in bit 23. Its payload is tagged as opcode arguments.
- R6: A parity bit is correct when it equals 1 for a field with an even number of ones and 0 for an odd number. On any mismatch in a type-4 or type-7 header, `err_bad_parity` pulses and the header fields are not updated. The header's count of following words is then taken with `in_ready`=1 and `pl_valid`=0.
- R7: A type-2 header is a no-op. It gives `hdr_valid` with `hdr_count`=0, and the next word is parsed as a header.
- R8: A type-4 or type-7 header with a count of zero is a complete packet on its own, and the next word is parsed as a header.
- R9: While idle, `in_ready`=1 and `pl_valid`=0. During a payload, `pl_valid`=`in_valid`, `pl_data`=`in_word`, and `in_ready`=`pl_ready`.
- R10: On the cycle after a header is taken, exactly one of `hdr_valid`, `err_bad_type` and `err_bad_parity` is high for one cycle. `hdr_kind` is coded 0 = type 0, 1 = type 2, 2 = type 3, 3 = type 4 and 4 = type 7. Fields that a format does not carry read as zero.
- R11: `pl_reg` rises by one only for each payload word that is accepted, and holds during a stall. `pl_last` marks the final word of the payload.
- R12: During reset and right after it, `in_ready`=1 and the three header pulses and `pl_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Command word |
| hdr_valid | output | 1 | Pulse: a good header was decoded |
| hdr_kind | output | 3 | Header format code |
| hdr_count | output | 15 | Number of payload words |
| hdr_reg | output | 18 | Register index (types 0 and 4) |
| hdr_opc | output | 8 | Opcode (types 3 and 7) |
| err_bad_type | output | 1 | Pulse: unknown header type |
| err_bad_parity | output | 1 | Pulse: header parity mismatch |
| pl_valid | output | 1 | Payload word valid |
| pl_ready | input | 1 | Downstream accepts payload word |
| pl_data | output | 32 | Payload word |
| pl_is_reg | output | 1 | 1 = register write, 0 = opcode argument |
| pl_reg | output | 18 | Register index for this word |
| pl_opc | output | 8 | Opcode this word belongs to |
| pl_last | output | 1 | Final word of the payload |

## Verification
The bench goes after three kinds of corner case: the count offset, the end of a packet, and the error paths. On the count offset, types 0 and 3 store the count minus one while types 4 and 7 store the count itself. A design that mixed these up would pass one word too many or too few. That would desynchronise the stream, so a payload word would later be parsed as a header. At the end of a packet, the bench covers zero-count packets and type-2 no-ops, which must not swallow the next word. A design that got this wrong would emit a spurious payload word. On the error paths, it corrupts each parity bit in turn and feeds in unknown type nibbles. The expected result is that the corrupt packet's payload is silently drained and that the stream stays aligned. Random stalls on `pl_ready` check that `pl_reg` advances only on words that are actually taken. The type-0 register index is also carried past bit 14 to check that the increment uses the full index width.

// File: rtl/cph_pkg.sv
package cph_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 15;
  localparam int REG_W  = 18;
  localparam int OPC_W  = 8;

  typedef enum logic [2:0] {
    PK_T0 = 3'd0,
    PK_T2 = 3'd1,
    PK_T3 = 3'd2,
    PK_T4 = 3'd3,
    PK_T7 = 3'd4
  } pkt_kind_e;

  typedef struct packed {
    logic              ok_type;
    pkt_kind_e         kind;
    logic              par_bad;
    logic [CNT_W-1:0]  count;
    logic [REG_W-1:0]  reg_idx;
    logic [OPC_W-1:0]  opc;
    logic              has_reg;
  } hdr_t;

  // Fold the nibbles together and look the result up in a 16-entry
  // parity table: gives 1 when the value holds an even number of ones.
  function automatic logic nib_par(input logic [WORD_W-1:0] v);
    logic [3:0]  acc;
    logic [15:0] tbl;
    acc = '0;
    for (int i = 0; i < WORD_W / 4; i++) acc = acc ^ v[i*4 +: 4];
    tbl = 16'h9669;
    return tbl[acc];
  endfunction

endpackage

// File: rtl/cph_decode.sv
module cph_decode
  import cph_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              dec
);

  always_comb begin
    dec         = '0;
    dec.ok_type = 1'b1;
    dec.kind    = PK_T2;
    unique case (word[31:28])
      4'h0: begin
        dec.kind    = PK_T0;
        dec.has_reg = 1'b1;
        dec.reg_idx = REG_W'(word[14:0]);
        dec.count   = CNT_W'(word[27:16]) + CNT_W'(1);
      end
      4'hC: begin
        dec.kind  = PK_T3;
        dec.opc   = word[15:8];
        dec.count = CNT_W'(word[27:16]) + CNT_W'(1);
      end
      4'h8: begin
        dec.kind = PK_T2;
      end
      4'h4: begin
        dec.kind    = PK_T4;
        dec.has_reg = 1'b1;
        dec.count   = CNT_W'(word[6:0]);
        dec.reg_idx = word[25:8];
        dec.par_bad = (word[7]  != nib_par(WORD_W'(word[6:0]))) ||
                      (word[27] != nib_par(WORD_W'(word[25:8])));
      end
      4'h7: begin
        dec.kind    = PK_T7;
        dec.count   = CNT_W'(word[13:0]);
        dec.opc     = OPC_W'(word[22:16]);
        dec.par_bad = (word[15] != nib_par(WORD_W'(word[13:0]))) ||
                      (word[23] != nib_par(WORD_W'(word[22:16])));
      end
      default: begin
        dec.ok_type = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cph_hdr_out.sv
module cph_hdr_out
  import cph_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_take,
  input  hdr_t             dec,
  output logic             hdr_valid,
  output logic [2:0]       hdr_kind,
  output logic [CNT_W-1:0] hdr_count,
  output logic [REG_W-1:0] hdr_reg,
  output logic [OPC_W-1:0] hdr_opc,
  output logic             err_bad_type,
  output logic             err_bad_parity
);

  logic unused_dec;
  assign unused_dec = dec.has_reg;

  logic good;
  assign good = dec.ok_type && !dec.par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_valid      <= 1'b0;
      err_bad_type   <= 1'b0;
      err_bad_parity <= 1'b0;
      hdr_kind       <= '0;
      hdr_count      <= '0;
      hdr_reg        <= '0;
      hdr_opc        <= '0;
    end else begin
      hdr_valid      <= hdr_take && good;
      err_bad_type   <= hdr_take && !dec.ok_type;
      err_bad_parity <= hdr_take && dec.ok_type && dec.par_bad;
      if (hdr_take && good) begin
        hdr_kind  <= dec.kind;
        hdr_count <= dec.count;
        hdr_reg   <= dec.reg_idx;
        hdr_opc   <= dec.opc;
      end
    end
  end

endmodule

// File: rtl/cph_payload_seq.sv
module cph_payload_seq
  import cph_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  hdr_t              dec,
  output logic              hdr_take,
  output logic              pl_valid,
  input  logic              pl_ready,
  output logic [WORD_W-1:0] pl_data,
  output logic              pl_is_reg,
  output logic [REG_W-1:0]  pl_reg,
  output logic [OPC_W-1:0]  pl_opc,
  output logic              pl_last
);

  logic unused_dec;
  assign unused_dec = ^{dec.ok_type, dec.kind};

  logic             busy_q, drop_q, isreg_q;
  logic [CNT_W-1:0] left_q;
  logic [REG_W-1:0] reg_q;
  logic [OPC_W-1:0] opc_q;
  logic             pay_take;

  assign in_ready  = !busy_q || drop_q || pl_ready;
  assign hdr_take  = in_valid && !busy_q;
  assign pay_take  = in_valid && busy_q && in_ready;
  assign pl_valid  = in_valid && busy_q && !drop_q;
  assign pl_data   = in_word;
  assign pl_is_reg = isreg_q;
  assign pl_reg    = reg_q;
  assign pl_opc    = opc_q;
  assign pl_last   = (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      drop_q  <= 1'b0;
      isreg_q <= 1'b0;
      left_q  <= '0;
      reg_q   <= '0;
      opc_q   <= '0;
    end else if (hdr_take) begin
      // unknown types and no-ops decode with a zero count
      busy_q  <= (dec.count != '0);
      drop_q  <= dec.par_bad;
      left_q  <= dec.count;
      reg_q   <= dec.reg_idx;
      opc_q   <= dec.opc;
      isreg_q <= dec.has_reg;
    end else if (pay_take) begin
      left_q <= left_q - CNT_W'(1);
      reg_q  <= reg_q + REG_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_hdr_parser.sv
module cmd_hdr_parser
  import cph_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        hdr_valid,
  output logic [2:0]  hdr_kind,
  output logic [14:0] hdr_count,
  output logic [17:0] hdr_reg,
  output logic [7:0]  hdr_opc,
  output logic        err_bad_type,
  output logic        err_bad_parity,
  output logic        pl_valid,
  input  logic        pl_ready,
  output logic [31:0] pl_data,
  output logic        pl_is_reg,
  output logic [17:0] pl_reg,
  output logic [7:0]  pl_opc,
  output logic        pl_last
);

  hdr_t dec;
  logic hdr_take;

  cph_decode u_dec (
    .word (in_word),
    .dec  (dec)
  );

  cph_payload_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .dec       (dec),
    .hdr_take  (hdr_take),
    .pl_valid  (pl_valid),
    .pl_ready  (pl_ready),
    .pl_data   (pl_data),
    .pl_is_reg (pl_is_reg),
    .pl_reg    (pl_reg),
    .pl_opc    (pl_opc),
    .pl_last   (pl_last)
  );

  cph_hdr_out u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .hdr_take       (hdr_take),
    .dec            (dec),
    .hdr_valid      (hdr_valid),
    .hdr_kind       (hdr_kind),
    .hdr_count      (hdr_count),
    .hdr_reg        (hdr_reg),
    .hdr_opc        (hdr_opc),
    .err_bad_type   (err_bad_type),
    .err_bad_parity (err_bad_parity)
  );

endmodule

// File: rtl/cph_checker.sv
module cph_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        hdr_valid,
  input logic [2:0]  hdr_kind,
  input logic [14:0] hdr_count,
  input logic        err_bad_type,
  input logic        err_bad_parity,
  input logic        pl_valid,
  input logic        pl_ready,
  input logic [17:0] pl_reg,
  input logic        pl_last
);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_valid, err_bad_type, err_bad_parity}));

  assert_stall_holds_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready) |-> !in_ready);

  assert_reg_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && !pl_last) |=> (pl_reg == $past(pl_reg) + 18'd1));

  assert_reg_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready) |=> $stable(pl_reg));

  assert_minus_one_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && (hdr_kind == 3'd0 || hdr_kind == 3'd2)) |-> (hdr_count != 15'd0));

  assert_noop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_kind == 3'd1) |-> (hdr_count == 15'd0));

endmodule

bind cmd_hdr_parser cph_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .hdr_valid      (hdr_valid),
  .hdr_kind       (hdr_kind),
  .hdr_count      (hdr_count),
  .err_bad_type   (err_bad_type),
  .err_bad_parity (err_bad_parity),
  .pl_valid       (pl_valid),
  .pl_ready       (pl_ready),
  .pl_reg         (pl_reg),
  .pl_last        (pl_last)
);

// File: tb/tb_cmd_hdr_parser.sv
module tb_cmd_hdr_parser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, pl_ready;
  logic [31:0] in_word;
  logic        hdr_valid, err_bad_type, err_bad_parity;
  logic [2:0]  hdr_kind;
  logic [14:0] hdr_count;
  logic [17:0] hdr_reg, pl_reg;
  logic [7:0]  hdr_opc, pl_opc;
  logic        pl_valid, pl_is_reg, pl_last;
  logic [31:0] pl_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cmd_hdr_parser dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
    .hdr_count(hdr_count), .hdr_reg(hdr_reg), .hdr_opc(hdr_opc),
    .err_bad_type(err_bad_type), .err_bad_parity(err_bad_parity),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .pl_is_reg(pl_is_reg), .pl_reg(pl_reg), .pl_opc(pl_opc), .pl_last(pl_last)
  );

  task automatic ck(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference parity: 1 when the field holds an even number of ones
  function automatic logic bpar(input logic [31:0] v);
    return ~(^v);
  endfunction

  function automatic logic [31:0] f_t0(input logic [14:0] r, input int cnt);
    logic [11:0] c = 12'(cnt - 1);
    return {4'h0, c, 1'b0, r};
  endfunction

  function automatic logic [31:0] f_t3(input logic [7:0] op, input int cnt);
    logic [11:0] c = 12'(cnt - 1);
    return {4'hC, c, op, 8'h00};
  endfunction

  function automatic logic [31:0] f_t4(input logic [17:0] r, input logic [6:0] c,
                                       input bit bc, input bit br);
    return {4'h4, bpar(32'(r)) ^ br, 1'b0, r, bpar(32'(c)) ^ bc, c};
  endfunction

  function automatic logic [31:0] f_t7(input logic [6:0] op, input logic [13:0] c,
                                       input bit bc, input bit bo);
    return {4'h7, 4'h0, bpar(32'(op)) ^ bo, op, bpar(32'(c)) ^ bc, 1'b0, c};
  endfunction

  // called and returns at a falling edge
  task automatic run_pkt(input logic [31:0] w, input string rq,
                         input bit e_ok, input bit e_ty, input bit e_par,
                         input int e_kind, input int e_cnt, input int e_reg,
                         input int e_opc, input int npay, input bit isreg, input bit drop);
    in_valid = 1'b1;
    in_word  = w;
    pl_ready = 1'($urandom % 2);
    #1;
    ck("R9", "in_ready while idle", in_ready, 1);
    ck("R9", "no pl_valid on header", pl_valid, 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    ck(rq, "hdr_valid", hdr_valid, e_ok);
    ck("R1", "err_bad_type", err_bad_type, e_ty);
    ck("R6", "err_bad_parity", err_bad_parity, e_par);
    if (e_ok) begin
      ck("R10", "hdr_kind", hdr_kind, e_kind);
      ck(rq, "hdr_count", hdr_count, e_cnt);
      ck(rq, "hdr_reg", hdr_reg, e_reg);
      ck(rq, "hdr_opc", hdr_opc, e_opc);
    end
    for (int i = 0; i < npay; i++) begin
      logic [31:0] d = $urandom;
      bit taken = 1'b0;
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        #1 ck("R9", "no pl_valid in gap", pl_valid, 0);
        @(posedge clk);
        @(negedge clk);
      end
      while (!taken) begin
        in_valid = 1'b1;
        in_word  = d;
        pl_ready = 1'($urandom % 3 != 0);
        #1;
        if (drop) begin
          ck("R6", "drained word hidden", pl_valid, 0);
          ck("R6", "drained word taken", in_ready, 1);
        end else begin
          ck("R9", "pl_valid", pl_valid, 1);
          ck("R9", "pl_data", pl_data, d);
          ck("R9", "in_ready follows pl_ready", in_ready, pl_ready);
          ck(rq, "pl_is_reg", pl_is_reg, isreg);
          if (isreg) ck("R11", "pl_reg", pl_reg, (e_reg + i) & 32'h3FFFF);
          else ck(rq, "pl_opc", pl_opc, e_opc);
          ck("R11", "pl_last", pl_last, (i == npay - 1));
        end
        taken = in_ready;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    in_valid = 1'b0;
    in_word  = '0;
    pl_ready = 1'b0;
    repeat (3) @(negedge clk);
    ck("R12", "in_ready in reset", in_ready, 1);
    ck("R12", "pl_valid in reset", pl_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ck("R12", "hdr_valid after reset", hdr_valid, 0);
    ck("R12", "err pulses after reset", err_bad_type | err_bad_parity, 0);

    // directed corners
    run_pkt(32'h8123_4567, "R7", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    run_pkt(f_t0(15'h7FFE, 3), "R2", 1, 0, 0, 0, 3, 'h7FFE, 0, 3, 1, 0);
    run_pkt(f_t0(15'h0010, 1), "R2", 1, 0, 0, 0, 1, 'h10, 0, 1, 1, 0);
    run_pkt(f_t3(8'hA5, 4), "R3", 1, 0, 0, 2, 4, 0, 'hA5, 4, 0, 0);
    run_pkt(f_t4(18'h3FFFF, 7'd0, 0, 0), "R8", 1, 0, 0, 3, 0, 'h3FFFF, 0, 0, 1, 0);
    run_pkt(f_t4(18'h2_0001, 7'd127, 0, 0), "R4", 1, 0, 0, 3, 127, 'h20001, 0, 127, 1, 0);
    run_pkt(f_t7(7'h7F, 14'd0, 0, 0), "R8", 1, 0, 0, 4, 0, 0, 'h7F, 0, 0, 0);
    run_pkt(f_t7(7'h15, 14'd5, 0, 0), "R5", 1, 0, 0, 4, 5, 0, 'h15, 5, 0, 0);
    run_pkt(f_t4(18'h00123, 7'd3, 1, 0), "R6", 0, 0, 1, 0, 0, 0, 0, 3, 1, 1);
    run_pkt(f_t4(18'h00123, 7'd2, 0, 1), "R6", 0, 0, 1, 0, 0, 0, 0, 2, 1, 1);
    run_pkt(f_t7(7'h33, 14'd2, 0, 1), "R6", 0, 0, 1, 0, 0, 0, 0, 2, 0, 1);
    run_pkt(f_t7(7'h33, 14'd4, 1, 0), "R6", 0, 0, 1, 0, 0, 0, 0, 4, 0, 1);
    run_pkt(f_t4(18'h00001, 7'd0, 1, 0), "R6", 0, 0, 1, 0, 0, 0, 0, 0, 1, 1);
    run_pkt(32'h1000_0005, "R1", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_pkt(32'hF000_0000, "R1", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_pkt(f_t0(15'h0040, 2), "R1", 1, 0, 0, 0, 2, 'h40, 0, 2, 1, 0);

    // random packet mix
    for (int k = 0; k < 80; k++) begin
      int sel = $urandom % 6;
      case (sel)
        0: begin
          int c = 1 + $urandom % 5;
          logic [14:0] r = 15'($urandom);
          run_pkt(f_t0(r, c), "R2", 1, 0, 0, 0, c, int'(r), 0, c, 1, 0);
        end
        1: begin
          int c = 1 + $urandom % 5;
          logic [7:0] op = 8'($urandom);
          run_pkt(f_t3(op, c), "R3", 1, 0, 0, 2, c, 0, int'(op), c, 0, 0);
        end
        2: begin
          run_pkt(32'h8000_0000 | ($urandom & 32'h0FFF_FFFF), "R7", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        end
        3: begin
          int c = $urandom % 6;
          logic [17:0] r = 18'($urandom);
          bit bc = ($urandom % 5 == 0);
          bit br = ($urandom % 5 == 0);
          bit bad = bc | br;
          run_pkt(f_t4(r, 7'(c), bc, br), bad ? "R6" : "R4", !bad, 0, bad,
                  3, c, int'(r), 0, c, 1, bad);
        end
        4: begin
          int c = $urandom % 6;
          logic [6:0] op = 7'($urandom);
          bit bc = ($urandom % 5 == 0);
          bit bo = ($urandom % 5 == 0);
          bit bad = bc | bo;
          run_pkt(f_t7(op, 14'(c), bc, bo), bad ? "R6" : "R5", !bad, 0, bad,
                  4, c, 0, int'(op), c, 0, bad);
        end
        default: begin
          logic [3:0] nib = 4'($urandom);
          while (nib == 4'h0 || nib == 4'h8 || nib == 4'hC || nib == 4'h4 || nib == 4'h7)
            nib = 4'($urandom);
          run_pkt({nib, 28'($urandom)}, "R1", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule